// File: doc/BRIEF.md
# NAND Page Single-Error ECC Engine

This block sits beside the data bus of a NAND flash controller. It watches the words of one page as they go by and computes a whole-page Hamming code over every bit. The code can correct one flipped bit and detect two. The controller pulses a start strobe and names the page size, the bus width and the direction. It then presents one word per data-valid strobe. On a write, the finished code appears on the two 16-bit parity outputs, ready to be stored as four check bytes. On a read, the four stored check bytes must be presented right after the last data word. The controller may have jumped the column into the spare area to fetch them. The engine folds them into its own code, classifies the outcome and reports where a single flipped bit sits.

The code is two halves, each as wide as a bit address. The bit address of a data bit is `{word index, lane}`. The "odd" half holds, for each address bit k, the XOR of all data bits whose address has bit k set. The "even" half holds the XOR of those whose address has bit k clear. A single flipped data bit therefore yields an odd syndrome equal to its address and an even syndrome equal to the address's complement.

Top module: `ecc_page_engine`

## Requirements
- R1: After reset, both parity outputs and all three status flags are zero.
- R2: After a write page, `parity_lo` holds the odd half and `parity_hi` holds the even half of the page code, and all three flags are clear. Bit k of the odd half is the XOR of every data bit whose address {word index, lane} has bit k set; bit k of the even half covers the data bits whose address has bit k clear.
- R3: `cfg_size` = s selects a data area of BASE_BYTES·2^s bytes. On the narrow bus (`cfg_wide`=0) each strobe carries one byte on `din[7:0]`, and `din[15:8]` is ignored. On the wide bus each strobe carries two bytes, low byte first in `din[7:0]`, and there are half as many words.
- R4: On a read, the check bytes follow the last data word directly. On the narrow bus they are four strobes with bytes 0 and 1 holding the odd half, low byte first, then bytes 2 and 3 holding the even half. On the wide bus they are two strobes: the odd half, then the even half.
- R5: A read whose data and check bytes agree leaves all flags clear and both parity outputs zero.
- R6: A read with exactly one flipped data bit sets only the recoverable flag. `parity_lo` then reads {word offset[11:0], bit offset[3:0]} of that exact bit, and `parity_hi` reads its complement.
- R7: A read with exactly one flipped check bit sets both the recoverable flag and the check-byte flag, and clears the multiple flag. The parity outputs then show a single set bit at the flipped check-bit position (0 to 31 across lo then hi).
- R8: A read with two flipped data bits sets the recoverable flag and the multiple flag, and clears the check-byte flag.
- R9: A read of an erased page (all data and check bytes 0xFF) sets the multiple flag with both offset fields all ones (`parity_lo` = 16'hFFFF). Software uses this to tell an erased page from a corrupt one.
- R10: Outputs change only on the clock edge one cycle after the final word of a page is accepted. Cycles with `dv` low inside a page do not advance the page.
- R11: A start strobe in the middle of a page discards the partial page and restarts accumulation without touching the outputs.
- R12: Strobes on `dv` outside a page change neither the outputs nor the next page's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Page size select, latched at start |
| cfg_wide | input | 1 | 1 = 16-bit bus, latched at start |
| page_start | input | 1 | Start-of-page pulse, clears the accumulators |
| page_read | input | 1 | 1 = read page (check bytes follow), latched at start |
| dv | input | 1 | Data-valid strobe for `din` |
| din | input | 16 | Bus word |
| parity_lo | output | 16 | Odd half of code (write) or odd syndrome / error location (read) |
| parity_hi | output | 16 | Even half of code (write) or even syndrome (read) |
| st_recov | output | 1 | Any mismatch seen on the last read |
| st_multi | output | 1 | Mismatch not correctable as a single bit |
| st_eccbit | output | 1 | Single flipped bit lies in the check bytes |

## Verification
The bench flips every bit position of a short page, on both bus widths, and checks the exact reported location. A design with a misrouted lane or word-address bit would point at the wrong bit. It also flips each of the 32 check bits. A design that mapped the check bytes out of order or confused check errors with data errors would either report a bogus data location or raise the multiple flag. The erased-page read catches a design whose syndrome for all-ones data is not all ones. Idle strobes, mid-page restarts, gaps in `dv` and junk in the upper byte on the narrow bus catch counters that advance when they should not and outputs that update early or twice.

// File: rtl/ecc_pg_pkg.sv
package ecc_pg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_CHK  = 2'd2
   } ph_e;

   typedef struct packed {
      logic recov;
      logic multi;
      logic eccbit;
   } verdict_t;

endpackage

// File: rtl/ecc_pg_seq.sv
module ecc_pg_seq
   import ecc_pg_pkg::*;
#(
   parameter int BASE_BYTES = 512,
   parameter int N_SIZES    = 4,
   parameter int WA_W       = 12,
   parameter int CHK_UNITS  = 4,
   parameter int SEL_W      = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         page_start,
   input  logic [SEL_W-1:0]             size_sel,
   input  logic                         wide,
   input  logic                         rd,
   input  logic                         dv,
   output logic                         data_we,
   output logic                         chk_we,
   output logic [WA_W-1:0]              word_idx,
   output logic [$clog2(CHK_UNITS)-1:0] chk_idx,
   output logic                         acc_clr,
   output logic                         upd,
   output logic                         wide_q,
   output logic                         rd_q
);

   localparam int CNT_W = WA_W;
   localparam int CI_W  = $clog2(CHK_UNITS);
   localparam logic [CNT_W:0]   BASE_V = (CNT_W+1)'(BASE_BYTES);
   localparam logic [CNT_W-1:0] LCHK_N = CNT_W'(CHK_UNITS - 1);
   localparam logic [CNT_W-1:0] LCHK_W = CNT_W'(CHK_UNITS/2 - 1);

   if (BASE_BYTES < 2 || (BASE_BYTES & (BASE_BYTES - 1)) != 0) begin : g_bad_base
      $error("BASE_BYTES must be a power of two of at least 2");
   end
   if ((BASE_BYTES << (N_SIZES - 1)) > (1 << WA_W)) begin : g_bad_span
      $error("largest page does not fit the word address");
   end
   if (CHK_UNITS < 2 || (CHK_UNITS % 2) != 0 || CI_W > CNT_W) begin : g_bad_chk
      $error("check unit count must be even and addressable");
   end

   ph_e              ph;
   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W:0]   n_bytes;
   logic [CNT_W:0]   n_words;
   logic [CNT_W-1:0] last_data;
   logic [CNT_W-1:0] last_chk;
   logic             take;
   logic             fin;

   always_comb begin
      n_bytes   = BASE_V << sel_q;
      n_words   = wide_q ? (n_bytes >> 1) : n_bytes;
      last_data = CNT_W'(n_words - 1'b1);
      last_chk  = wide_q ? LCHK_W : LCHK_N;
   end

   assign take     = dv && !page_start;
   assign data_we  = take && (ph == PH_DATA);
   assign chk_we   = take && (ph == PH_CHK);
   assign fin      = (data_we && (cnt == last_data) && !rd_q) ||
                     (chk_we && (cnt == last_chk));
   assign word_idx = cnt;
   assign chk_idx  = cnt[CI_W-1:0];
   assign acc_clr  = page_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cnt    <= '0;
         sel_q  <= '0;
         wide_q <= 1'b0;
         rd_q   <= 1'b0;
         upd    <= 1'b0;
      end else begin
         upd <= fin;
         if (page_start) begin
            ph     <= PH_DATA;
            cnt    <= '0;
            sel_q  <= size_sel;
            wide_q <= wide;
            rd_q   <= rd;
         end else if (data_we) begin
            if (cnt == last_data) begin
               cnt <= '0;
               ph  <= rd_q ? PH_CHK : PH_IDLE;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (chk_we) begin
            if (cnt == last_chk) begin
               cnt <= '0;
               ph  <= PH_IDLE;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R3: the word counter never runs past the selected page length
   a_r3_cnt_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DATA) |-> (cnt <= last_data));

   // R11: a start strobe always lands on the first data word
   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      page_start |=> (ph == PH_DATA) && (cnt == '0));

endmodule

// File: rtl/ecc_pg_acc.sv
module ecc_pg_acc #(
   parameter int WA_W      = 12,
   parameter int BA_W      = 4,
   parameter int CHK_UNITS = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         data_we,
   input  logic                         chk_we,
   input  logic                         wide,
   input  logic [WA_W-1:0]              word_idx,
   input  logic [$clog2(CHK_UNITS)-1:0] chk_idx,
   input  logic [(1<<BA_W)-1:0]         din,
   output logic [WA_W+BA_W-1:0]         odd_q,
   output logic [WA_W+BA_W-1:0]         even_q
);

   localparam int BUS_W  = 1 << BA_W;
   localparam int NARROW = BUS_W / 2;
   localparam int PW     = WA_W + BA_W;
   localparam int CI_W   = $clog2(CHK_UNITS);

   if (2 * PW != CHK_UNITS * NARROW || (PW % BUS_W) != 0) begin : g_bad_geom
      $error("check units must tile both code halves on either bus");
   end

   function automatic logic [BUS_W-1:0] lane_mask(input int k);
      logic [BUS_W-1:0] m;
      m = '0;
      for (int b = 0; b < BUS_W; b++) m[b] = ((b >> k) & 1) == 1;
      return m;
   endfunction

   logic [BUS_W-1:0] lane_bit;
   logic             wpar;
   logic [PW-1:0]    co, ce;
   logic [2*PW-1:0]  chk_vec;

   for (genvar b = 0; b < BUS_W; b++) begin : g_lane
      if (b < NARROW) begin : g_low
         assign lane_bit[b] = din[b];
      end else begin : g_high
         assign lane_bit[b] = din[b] & wide;
      end
   end

   assign wpar = ^lane_bit;

   for (genvar k = 0; k < PW; k++) begin : g_addr
      if (k < BA_W) begin : g_bit
         assign co[k] = ^(lane_bit & lane_mask(k));
         assign ce[k] = ^(lane_bit & ~lane_mask(k));
      end else begin : g_word
         assign co[k] = word_idx[k-BA_W] & wpar;
         assign ce[k] = ~word_idx[k-BA_W] & wpar;
      end
   end

   always_comb begin
      chk_vec = '0;
      for (int i = 0; i < CHK_UNITS; i++) begin
         if (!wide && chk_idx == CI_W'(i))
            chk_vec[i*NARROW +: NARROW] = din[NARROW-1:0];
         if (wide && i < CHK_UNITS/2 && chk_idx == CI_W'(i))
            chk_vec[i*BUS_W +: BUS_W] = din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odd_q  <= '0;
         even_q <= '0;
      end else if (clr) begin
         odd_q  <= '0;
         even_q <= '0;
      end else if (data_we) begin
         odd_q  <= odd_q ^ co;
         even_q <= even_q ^ ce;
      end else if (chk_we) begin
         odd_q  <= odd_q ^ chk_vec[PW-1:0];
         even_q <= even_q ^ chk_vec[2*PW-1:PW];
      end
   end

   // R12: with no accepted word and no clear the code halves hold
   a_r12_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !data_we && !chk_we) |=> ($stable(odd_q) && $stable(even_q)));

endmodule

// File: rtl/ecc_pg_judge.sv
module ecc_pg_judge
   import ecc_pg_pkg::*;
#(
   parameter int PW = 16
) (
   input  logic [PW-1:0] od,
   input  logic [PW-1:0] ed,
   output verdict_t      v
);

   logic any_set;
   logic data_one;
   logic chk_one;

   assign any_set  = |{od, ed};
   assign data_one = &(od ^ ed);
   assign chk_one  = ($countones({od, ed}) == 1);

   always_comb begin
      v = '0;
      if (any_set) begin
         v.recov = 1'b1;
         if (!data_one) begin
            if (chk_one) v.eccbit = 1'b1;
            else         v.multi  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine
   import ecc_pg_pkg::*;
#(
   parameter int BASE_BYTES = 512,
   parameter int N_SIZES    = 4,
   parameter int WA_W       = 12,
   parameter int BA_W       = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               cfg_size,
   input  logic                     cfg_wide,
   input  logic                     page_start,
   input  logic                     page_read,
   input  logic                     dv,
   input  logic [(1<<BA_W)-1:0]     din,
   output logic [WA_W+BA_W-1:0]     parity_lo,
   output logic [WA_W+BA_W-1:0]     parity_hi,
   output logic                     st_recov,
   output logic                     st_multi,
   output logic                     st_eccbit
);

   localparam int PW        = WA_W + BA_W;
   localparam int BUS_W     = 1 << BA_W;
   localparam int NARROW    = BUS_W / 2;
   localparam int CHK_UNITS = 2 * PW / NARROW;
   localparam int CI_W      = $clog2(CHK_UNITS);

   if (N_SIZES < 2 || N_SIZES > 4) begin : g_bad_sizes
      $error("size select port carries two bits");
   end

   logic            data_we, chk_we, acc_clr, upd, wide_q, rd_q;
   logic [WA_W-1:0] word_idx;
   logic [CI_W-1:0] chk_idx;
   logic [PW-1:0]   odd_q, even_q;
   verdict_t        verdict;

   ecc_pg_seq #(
      .BASE_BYTES (BASE_BYTES),
      .N_SIZES    (N_SIZES),
      .WA_W       (WA_W),
      .CHK_UNITS  (CHK_UNITS),
      .SEL_W      (2)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .page_start (page_start),
      .size_sel   (cfg_size),
      .wide       (cfg_wide),
      .rd         (page_read),
      .dv         (dv),
      .data_we    (data_we),
      .chk_we     (chk_we),
      .word_idx   (word_idx),
      .chk_idx    (chk_idx),
      .acc_clr    (acc_clr),
      .upd        (upd),
      .wide_q     (wide_q),
      .rd_q       (rd_q)
   );

   ecc_pg_acc #(
      .WA_W      (WA_W),
      .BA_W      (BA_W),
      .CHK_UNITS (CHK_UNITS)
   ) i_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (acc_clr),
      .data_we  (data_we),
      .chk_we   (chk_we),
      .wide     (wide_q),
      .word_idx (word_idx),
      .chk_idx  (chk_idx),
      .din      (din),
      .odd_q    (odd_q),
      .even_q   (even_q)
   );

   ecc_pg_judge #(.PW(PW)) i_judge (
      .od (odd_q),
      .ed (even_q),
      .v  (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         parity_lo <= '0;
         parity_hi <= '0;
         st_recov  <= 1'b0;
         st_multi  <= 1'b0;
         st_eccbit <= 1'b0;
      end else if (upd) begin
         parity_lo <= odd_q;
         parity_hi <= even_q;
         st_recov  <= rd_q & verdict.recov;
         st_multi  <= rd_q & verdict.multi;
         st_eccbit <= rd_q & verdict.eccbit;
      end
   end

   // R10: results move only on the update strobe
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(parity_lo) && $stable(parity_hi) && $stable(st_recov) &&
                $stable(st_multi) && $stable(st_eccbit)));

   // R6: a lone recoverable flag means the two syndromes are complements
   a_r6_single_loc: assert property (@(posedge clk) disable iff (!rst_n)
      (st_recov && !st_multi && !st_eccbit) |-> ($countones(parity_lo ^ parity_hi) == PW));

   // R7: a check-byte error shows exactly one syndrome bit
   a_r7_chk_err: assert property (@(posedge clk) disable iff (!rst_n)
      st_eccbit |-> (st_recov && !st_multi && $countones({parity_hi, parity_lo}) == 1));

   // R8: the multiple flag never stands without the recoverable flag
   a_r8_multi: assert property (@(posedge clk) disable iff (!rst_n)
      st_multi |-> (st_recov && !st_eccbit));

endmodule

// File: tb/test_ecc_page_engine.sv
module test_ecc_page_engine;

   localparam int BASE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_size = '0;
   logic        cfg_wide = 1'b0;
   logic        page_start = 1'b0;
   logic        page_read = 1'b0;
   logic        dv = 1'b0;
   logic [15:0] din = '0;
   logic [15:0] parity_lo, parity_hi;
   logic        st_recov, st_multi, st_eccbit;

   always #2 clk = ~clk;

   ecc_page_engine #(.BASE_BYTES(BASE), .N_SIZES(4), .WA_W(12), .BA_W(4)) i_ecc_page_engine (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_wide(cfg_wide),
      .page_start(page_start), .page_read(page_read), .dv(dv), .din(din),
      .parity_lo(parity_lo), .parity_hi(parity_hi),
      .st_recov(st_recov), .st_multi(st_multi), .st_eccbit(st_eccbit)
   );

   int          n_tests = 0;
   int          n_fail = 0;
   logic [7:0]  pg [0:63];
   logic [15:0] exp_lo = '0, exp_hi = '0;
   logic [2:0]  exp_fl = '0;
   bit          exp_par = 1'b1;
   bit          mon_on = 1'b0;

   task automatic check_all(input string tag);
      logic [2:0] fl;
      fl = {st_recov, st_multi, st_eccbit};
      n_tests++;
      if (fl !== exp_fl || (exp_par && (parity_lo !== exp_lo || parity_hi !== exp_hi))) begin
         n_fail++;
         $display("FAIL %s: lo=%h hi=%h flags=%b expected lo=%h hi=%h flags=%b (parity checked=%0d)",
                  tag, parity_lo, parity_hi, fl, exp_lo, exp_hi, exp_fl, exp_par);
      end
   endtask

   // Every-cycle comparison against the model state (R10 hold behaviour)
   always @(negedge clk) if (mon_on) check_all("R10 per-cycle");

   function automatic logic [31:0] page_code(input int nbytes, input bit wide);
      logic [15:0] o, e;
      int nw, lanes, addr;
      logic bv;
      o = '0; e = '0;
      nw = wide ? nbytes / 2 : nbytes;
      lanes = wide ? 16 : 8;
      for (int w = 0; w < nw; w++) begin
         for (int b = 0; b < lanes; b++) begin
            bv = wide ? pg[2*w + b/8][b%8] : pg[w][b];
            addr = w * 16 + b;
            for (int k = 0; k < 16; k++) begin
               if (((addr >> k) & 1) == 1) o[k] = o[k] ^ bv;
               else                        e[k] = e[k] ^ bv;
            end
         end
      end
      return {e, o};
   endfunction

   task automatic fill_random();
      for (int i = 0; i < 64; i++) pg[i] = 8'($urandom);
   endtask

   task automatic run_page(input string tag, input int sel, input bit wide, input bit rd,
                           input logic [31:0] stored, input int gap,
                           input logic [15:0] nlo, input logic [15:0] nhi,
                           input logic [2:0] nfl, input bit npar);
      int nw;
      nw = wide ? (BASE << sel) / 2 : (BASE << sel);
      @(negedge clk);
      page_start = 1'b1; cfg_size = 2'(sel); cfg_wide = wide; page_read = rd;
      dv = 1'b1; din = 16'($urandom);
      @(negedge clk);
      page_start = 1'b0;
      for (int w = 0; w < nw; w++) begin
         if (gap > 0 && (w % gap) == gap - 1) begin
            dv = 1'b0; din = 16'($urandom);
            @(negedge clk);
         end
         dv = 1'b1;
         din = wide ? {pg[2*w+1], pg[2*w]} : {8'($urandom), pg[w]};
         @(negedge clk);
      end
      if (rd) begin
         for (int u = 0; u < (wide ? 2 : 4); u++) begin
            dv = 1'b1;
            din = wide ? stored[u*16 +: 16] : {8'($urandom), stored[u*8 +: 8]};
            @(negedge clk);
         end
      end
      dv = 1'b0; din = 16'($urandom);
      @(posedge clk);
      #1;
      exp_lo = nlo; exp_hi = nhi; exp_fl = nfl; exp_par = npar;
      @(negedge clk);
      #1;
      check_all(tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] code, st;
      logic [15:0] loc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check_all("R1 reset state");
      mon_on = 1'b1;

      // R2 / R3: write pages of every size on both buses
      for (int wd = 0; wd < 2; wd++) begin
         for (int s = 0; s < 4; s++) begin
            fill_random();
            code = page_code(BASE << s, wd == 1);
            run_page(wd == 1 ? "R2 R3 write wide" : "R2 R3 write narrow",
                     s, wd == 1, 1'b0, 32'h0, 0, code[15:0], code[31:16], 3'b000, 1'b1);
         end
      end

      // R4 / R5: clean reads
      for (int wd = 0; wd < 2; wd++) begin
         for (int s = 0; s < 4; s++) begin
            fill_random();
            code = page_code(BASE << s, wd == 1);
            run_page("R4 R5 clean read", s, wd == 1, 1'b1, code, 0, 16'h0, 16'h0, 3'b000, 1'b1);
         end
      end

      // R6: every single data-bit position of a short page, narrow bus
      for (int p = 0; p < BASE * 8; p++) begin
         fill_random();
         code = page_code(BASE, 1'b0);
         pg[p/8][p%8] = ~pg[p/8][p%8];
         loc = 16'((p / 8) * 16 + (p % 8));
         run_page("R6 single data flip narrow", 0, 1'b0, 1'b1, code, 0, loc, ~loc, 3'b100, 1'b1);
      end
      // R6: every position, wide bus
      for (int p = 0; p < BASE * 8; p++) begin
         fill_random();
         code = page_code(BASE, 1'b1);
         pg[2*(p/16) + (p%16)/8][p%8] = ~pg[2*(p/16) + (p%16)/8][p%8];
         loc = 16'((p / 16) * 16 + (p % 16));
         run_page("R6 single data flip wide", 0, 1'b1, 1'b1, code, 0, loc, ~loc, 3'b100, 1'b1);
      end
      // R6 on the largest page, a few far positions
      for (int p = 500; p < 512; p++) begin
         fill_random();
         code = page_code(BASE << 3, 1'b0);
         pg[p/8][p%8] = ~pg[p/8][p%8];
         loc = 16'((p / 8) * 16 + (p % 8));
         run_page("R6 single flip large page", 3, 1'b0, 1'b1, code, 0, loc, ~loc, 3'b100, 1'b1);
      end

      // R7: every check-bit flip, narrow and wide
      for (int wd = 0; wd < 2; wd++) begin
         for (int j = 0; j < 32; j++) begin
            fill_random();
            st = page_code(BASE << 1, wd == 1) ^ (32'h1 << j);
            run_page("R7 check-byte flip", 1, wd == 1, 1'b1, st, 0,
                     st[15:0] ^ page_code(BASE << 1, wd == 1) ^ 16'h0 ? 16'h0 : 16'h0, 16'h0, 3'b101, 1'b0);
            loc = (j < 16) ? 16'(32'h1 << j) : 16'h0;
            n_tests++;
            if (parity_lo !== loc || parity_hi !== ((j >= 16) ? 16'(32'h1 << (j - 16)) : 16'h0)) begin
               n_fail++;
               $display("FAIL R7 location: lo=%h hi=%h expected single bit %0d", parity_lo, parity_hi, j);
            end
         end
      end

      // R8: two flipped data bits
      for (int t = 0; t < 12; t++) begin
         int a, b;
         fill_random();
         code = page_code(BASE << 2, t % 2 == 1);
         a = t * 7;
         b = a + 1 + t * 13;
         pg[a/8][a%8] = ~pg[a/8][a%8];
         pg[b/8][b%8] = ~pg[b/8][b%8];
         run_page("R8 double data flip", 2, t % 2 == 1, 1'b1, code, 0, 16'h0, 16'h0, 3'b110, 1'b0);
      end

      // R9: erased pages
      for (int wd = 0; wd < 2; wd++) begin
         for (int i = 0; i < 64; i++) pg[i] = 8'hFF;
         run_page("R9 erased page", 1, wd == 1, 1'b1, 32'hFFFF_FFFF, 0,
                  16'hFFFF, 16'hFFFF, 3'b110, 1'b1);
      end

      // R10: gaps in the data-valid strobe
      fill_random();
      code = page_code(BASE << 2, 1'b0);
      run_page("R10 gapped write", 2, 1'b0, 1'b0, 32'h0, 3, code[15:0], code[31:16], 3'b000, 1'b1);
      fill_random();
      code = page_code(BASE << 1, 1'b1);
      run_page("R10 gapped read", 1, 1'b1, 1'b1, code, 2, 16'h0, 16'h0, 3'b000, 1'b1);

      // R11: restart in the middle of a page
      @(negedge clk);
      page_start = 1'b1; cfg_size = 2'd2; cfg_wide = 1'b0; page_read = 1'b1;
      @(negedge clk);
      page_start = 1'b0;
      for (int i = 0; i < 9; i++) begin
         dv = 1'b1; din = 16'($urandom);
         @(negedge clk);
      end
      dv = 1'b0;
      #1;
      check_all("R11 partial page leaves outputs");
      fill_random();
      code = page_code(BASE << 1, 1'b0);
      run_page("R11 restarted page", 1, 1'b0, 1'b0, 32'h0, 0, code[15:0], code[31:16], 3'b000, 1'b1);

      // R12: strobes outside any page
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         dv = 1'b1; din = 16'($urandom);
      end
      @(negedge clk);
      dv = 1'b0;
      #1;
      check_all("R12 idle strobes ignored");
      fill_random();
      code = page_code(BASE, 1'b1);
      run_page("R12 next page unaffected", 0, 1'b1, 1'b0, 32'h0, 0, code[15:0], code[31:16], 3'b000, 1'b1);

      mon_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule